// File: doc/BRIEF.md
# Byte-Parity Word Store with Error Logging

This block fronts a small on-chip word store for a 16-bit bus. Each word is kept with two extra check bits, one per byte, both of odd sense. Writes compute the check bits. Reads recompute them and compare against the stored copy. The store is split into eight banks of equal depth. One strobe line per bank selects the bank that takes part in an access. The write enable is broadcast to every bank, so only the strobed bank acts on it. Reads use the same strobe, and the bank outputs are ORed together.

A single control/status register sits in the top 8 KB of the 22-bit address space (the I/O page). Its word address is one of sixteen even locations from octal 17772100 to 17772136, chosen by a 4-bit strap input. Software turns checking on and off through this register. It can also force inverted check bits for diagnostics and read back the latched error. Because the address field in the register is only seven bits wide, it shows either the low or the high part of the failing address, as chosen by a view bit.

A read that meets bad check bits while checking is on sets a sticky flag and records address bits 21..11 of the failing access. A later error does not overwrite that record until software clears the flag.

Top module: `parity_mem_ctl`

## Requirements
- R1: A memory write stores the 16 data bits. A memory read returns them on `rd_data` with `rd_valid` high in the cycle after the request, and with `par_err` low while the word was written with normal check bits. Check bits are odd per byte: bit 0 covers data bits 7..0 and bit 1 covers data bits 15..8.
- R2: During a memory access, `bank_strobe` is one-hot, with the bank index equal to address bits 7..5. Address bits 4..1 give the word within the bank. At all other times `bank_strobe` is zero. `wr_strobe` is high for every memory write whatever the bank, and only the strobed bank keeps the data.
- R3: The register answers only at word address octal 17772100 + 2*`csr_base_sel`. Any other access whose address bits 21..13 are all ones drives no strobe and no `rd_valid`, and changes neither the register nor the store.
- R4: The register layout is as follows:
  - bit 15: error flag
  - bit 14: high-view select
  - bits 11..5: address field
  - bit 2: diagnostic inverted check bits
  - bit 0: check enable
  - all other bits read 0

  A software write stores bits 15, 14, 2 and 0. It also loads the address field into the portion selected by the high-view bit as it stood before the write.
- R5: While bit 2 is 1, both check bits of every written word are stored inverted, so reading that word later raises `par_err` with the data intact.
- R6: When bit 14 is 0, the address field reads failing address bits 17..11. When it is 1, the field reads bits 21..18 in field bits 3..0, and field bits 6..4 read 0.
- R7: With check enable 0, a bad read still pulses `par_err` but leaves the flag and the address record unchanged.
- R8: While the flag is 1, further bad reads leave the recorded address unchanged.
- R9: Both `rst_n` low and a one-cycle `bus_init` pulse clear the whole register to 0.
- R10: A capture and a software register write that land on the same edge leave the flag set and the address field holding the captured address. The other bits come from the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_init | input | 1 | Synchronous bus initialise, clears the register |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 22 | Byte address |
| req_wdata | input | 16 | Write data |
| csr_base_sel | input | 4 | Register location strap |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| bank_strobe | output | 8 | One-hot bank select |
| wr_strobe | output | 1 | Write enable to all banks |
| par_err | output | 1 | Check-bit mismatch on the current read |

## Verification
The functions that can collide are hardware error capture and a software write to the register. Both update on the edge that ends the read-data cycle. The bench provokes this by issuing a bad read and, in the very next cycle, a register write that clears the flag and zeroes the field. It then reads the register back and expects the flag set and the field holding the failing address. The same capture path is also judged alone: with checking disabled, with the flag already set, and through both halves of the address view.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int ADDR_W = 22;
  localparam int DATA_W = 16;
  localparam int WORD_W = DATA_W + 2;
  localparam int SEL_W  = 4;
  localparam int FLD_W  = 7;
  localparam int HI_W   = 4;
  localparam int CAP_W  = FLD_W + HI_W;
  localparam logic [12:0] CSR_BASE = 13'o12100;

  function automatic logic odd_bit(input logic [7:0] b);
    return ~(^b);
  endfunction

  function automatic logic [1:0] gen_check(input logic [DATA_W-1:0] d, input logic inv);
    return {odd_bit(d[15:8]), odd_bit(d[7:0])} ^ {2{inv}};
  endfunction

  function automatic logic check_bad(input logic [WORD_W-1:0] w);
    return !(^{w[17], w[15:8]}) || !(^{w[16], w[7:0]});
  endfunction

  function automatic logic [12:0] csr_offset(input logic [SEL_W-1:0] sel);
    return CSR_BASE + 13'({sel, 1'b0});
  endfunction

  function automatic logic [DATA_W-1:0] csr_pack(input logic flag, input logic hiview,
                                                 input logic [FLD_W-1:0] fld,
                                                 input logic inv, input logic en);
    return {flag, hiview, 2'b00, fld, 2'b00, inv, 1'b0, en};
  endfunction
endpackage

// File: rtl/pmc_decode.sv
module pmc_decode
  import pmc_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int OFF_W = 4
) (
  input  logic                     valid,
  input  logic                     write,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [SEL_W-1:0]         base_sel,
  output logic                     csr_wr,
  output logic                     csr_rd,
  output logic                     mem_rd,
  output logic                     mem_wr,
  output logic [OFF_W-1:0]         word_off,
  output logic [NBANK-1:0]         strobe
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int BANK_LO = OFF_W + 1;

  logic             io_page;
  logic             csr_hit;
  logic             mem_acc;
  logic [BANK_W-1:0] bank_idx;

  assign io_page  = &addr[ADDR_W-1:13];
  assign csr_hit  = valid && io_page && (addr[12:0] == csr_offset(base_sel));
  assign mem_acc  = valid && !io_page;
  assign csr_wr   = csr_hit && write;
  assign csr_rd   = csr_hit && !write;
  assign mem_wr   = mem_acc && write;
  assign mem_rd   = mem_acc && !write;
  assign word_off = addr[OFF_W:1];
  assign bank_idx = addr[BANK_LO + BANK_W - 1:BANK_LO];

  for (genvar g = 0; g < NBANK; g++) begin : g_strobe
    assign strobe[g] = mem_acc && (bank_idx == BANK_W'(g));
  end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OFF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] wword,
  output logic [WORD_W-1:0] rword
);
  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (sel && we) cells[off] <= wword;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rword <= '0;
    else if (sel && !we) rword <= cells[off];
    else               rword <= '0;
  end
endmodule

// File: rtl/pmc_csr.sv
module pmc_csr
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_init,
  input  logic              wr_en,
  input  logic              wr_flag,
  input  logic              wr_hiview,
  input  logic [FLD_W-1:0]  wr_field,
  input  logic              wr_inv,
  input  logic              wr_chk_en,
  input  logic              capture,
  input  logic [CAP_W-1:0]  cap_addr,
  output logic              flag,
  output logic              hiview,
  output logic              inv,
  output logic              chk_en,
  output logic [CAP_W-1:0]  err_store,
  output logic [DATA_W-1:0] rdata
);
  logic [FLD_W-1:0] lo_q;
  logic [HI_W-1:0]  hi_q;
  logic [FLD_W-1:0] view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0; hiview <= 1'b0; inv <= 1'b0; chk_en <= 1'b0;
      lo_q <= '0; hi_q <= '0;
    end else if (bus_init) begin
      flag <= 1'b0; hiview <= 1'b0; inv <= 1'b0; chk_en <= 1'b0;
      lo_q <= '0; hi_q <= '0;
    end else begin
      if (wr_en) begin
        flag   <= wr_flag;
        hiview <= wr_hiview;
        inv    <= wr_inv;
        chk_en <= wr_chk_en;
        if (hiview) hi_q <= wr_field[HI_W-1:0];
        else        lo_q <= wr_field;
      end
      if (capture) begin
        flag <= 1'b1;
        lo_q <= cap_addr[FLD_W-1:0];
        hi_q <= cap_addr[CAP_W-1:FLD_W];
      end
    end
  end

  assign view      = hiview ? FLD_W'(hi_q) : lo_q;
  assign err_store = {hi_q, lo_q};
  assign rdata     = csr_pack(flag, hiview, view, inv, chk_en);
endmodule

// File: rtl/parity_mem_ctl.sv
module parity_mem_ctl
  import pmc_pkg::*;
#(
  parameter int NBANK = 8,
  parameter int WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_init,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [21:0]       req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [3:0]        csr_base_sel,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic [7:0]        bank_strobe,
  output logic              wr_strobe,
  output logic              par_err
);
  localparam int OFF_W = $clog2(WORDS);

  logic              csr_wr, csr_rd, mem_rd, mem_wr;
  logic [OFF_W-1:0]  word_off;
  logic [NBANK-1:0]  strobe;
  logic [WORD_W-1:0] wword;
  logic [WORD_W-1:0] bank_q [NBANK];
  logic [WORD_W-1:0] rd_word;

  logic              err_flag, hiview, inv, pe_en;
  logic [CAP_W-1:0]  err_store;
  logic [DATA_W-1:0] csr_rdata;
  logic              capture;
  logic              bad_evt;

  logic              rd_valid_q, rd_csr_q;
  logic [DATA_W-1:0] csr_snap_q;
  logic [CAP_W-1:0]  rd_addr_q;

  pmc_decode #(.NBANK(NBANK), .OFF_W(OFF_W)) u_dec (
    .valid(req_valid), .write(req_write), .addr(req_addr), .base_sel(csr_base_sel),
    .csr_wr(csr_wr), .csr_rd(csr_rd), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .word_off(word_off), .strobe(strobe)
  );

  assign wword = {gen_check(req_wdata, inv), req_wdata};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    pmc_bank #(.DEPTH(WORDS), .OFF_W(OFF_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .sel(strobe[b]), .we(mem_wr),
      .off(word_off), .wword(wword), .rword(bank_q[b])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NBANK; b++) rd_word = rd_word | bank_q[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_csr_q   <= 1'b0;
      csr_snap_q <= '0;
      rd_addr_q  <= '0;
    end else begin
      rd_valid_q <= mem_rd || csr_rd;
      rd_csr_q   <= csr_rd;
      csr_snap_q <= csr_rdata;
      rd_addr_q  <= req_addr[ADDR_W-1:11];
    end
  end

  assign bad_evt = rd_valid_q && !rd_csr_q && check_bad(rd_word);
  assign capture = bad_evt && pe_en && !err_flag;

  pmc_csr u_csr (
    .clk(clk), .rst_n(rst_n), .bus_init(bus_init),
    .wr_en(csr_wr), .wr_flag(req_wdata[15]), .wr_hiview(req_wdata[14]),
    .wr_field(req_wdata[11:5]), .wr_inv(req_wdata[2]), .wr_chk_en(req_wdata[0]),
    .capture(capture), .cap_addr(rd_addr_q),
    .flag(err_flag), .hiview(hiview), .inv(inv), .chk_en(pe_en),
    .err_store(err_store), .rdata(csr_rdata)
  );

  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_csr_q ? csr_snap_q : rd_word[DATA_W-1:0];
  assign bank_strobe = 8'(strobe);
  assign wr_strobe   = mem_wr;
  assign par_err     = bad_evt;
endmodule

// File: rtl/parity_mem_ctl_chk.sv
module parity_mem_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_init,
  input logic        req_valid,
  input logic        req_write,
  input logic        rd_valid,
  input logic [7:0]  bank_strobe,
  input logic        wr_strobe,
  input logic        csr_wr,
  input logic        capture,
  input logic        err_flag,
  input logic        pe_en,
  input logic [10:0] err_store,
  input logic [15:0] csr_rdata
);
  a_r1_rdvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write));

  a_r2_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_strobe));

  a_r2_wr_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (req_valid && req_write && $countones(bank_strobe) == 1));

  a_r7_no_capture_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!pe_en && !err_flag && !csr_wr) |=> !err_flag);

  a_r8_record_held: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !csr_wr && !bus_init) |=> (err_flag && $stable(err_store)));

  a_r9_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_init |=> (csr_rdata == 16'h0000));

  a_r10_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !bus_init) |=> err_flag);
endmodule

bind parity_mem_ctl parity_mem_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .req_valid(req_valid),
  .req_write(req_write), .rd_valid(rd_valid), .bank_strobe(bank_strobe),
  .wr_strobe(wr_strobe), .csr_wr(csr_wr), .capture(capture),
  .err_flag(err_flag), .pe_en(pe_en), .err_store(err_store), .csr_rdata(csr_rdata)
);

// File: tb/parity_mem_ctl_bench.sv
module parity_mem_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [21:0] CSR_A   = 22'o17772112;
  localparam logic [21:0] OTHER_IO = 22'o17772100;
  localparam logic [21:0] ADDR_A  = 22'h2D5840;
  localparam logic [21:0] ADDR_B  = 22'h0C804A;

  localparam logic [38:0] VEC [16] = '{
    {1'b1, 22'h00000A, 16'h1E01}, {1'b1, 22'h00002A, 16'h2D12},
    {1'b1, 22'h00004A, 16'h3C23}, {1'b1, 22'h00006A, 16'h4B34},
    {1'b1, 22'h00008A, 16'h5A45}, {1'b1, 22'h0000AA, 16'h6956},
    {1'b1, 22'h0000CA, 16'h7867}, {1'b1, 22'h0000EA, 16'h8778},
    {1'b0, 22'h0000EA, 16'h8778}, {1'b0, 22'h0000CA, 16'h7867},
    {1'b0, 22'h0000AA, 16'h6956}, {1'b0, 22'h00008A, 16'h5A45},
    {1'b0, 22'h00006A, 16'h4B34}, {1'b0, 22'h00004A, 16'h3C23},
    {1'b0, 22'h00002A, 16'h2D12}, {1'b0, 22'h00000A, 16'h1E01}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_init = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0] csr_base_sel = 4'd5;
  logic rd_valid, wr_strobe, par_err;
  logic [15:0] rd_data;
  logic [7:0] bank_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_mem_ctl u_parity_mem_ctl (
    .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .csr_base_sel(csr_base_sel), .rd_valid(rd_valid), .rd_data(rd_data),
    .bank_strobe(bank_strobe), .wr_strobe(wr_strobe), .par_err(par_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [21:0] a, input logic [15:0] d,
                        output logic [15:0] rdat, output logic rv, output logic perr,
                        output logic [7:0] bs, output logic ws);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    bs = bank_strobe; ws = wr_strobe;
    @(negedge clk);
    rdat = rd_data; rv = rd_valid; perr = par_err;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic csr_write(input logic [15:0] d);
    logic [15:0] r; logic v, p, w; logic [7:0] s;
    access(1'b1, CSR_A, d, r, v, p, s, w);
  endtask

  task automatic csr_expect(input logic [15:0] exp, input string req);
    logic [15:0] r; logic v, p, w; logic [7:0] s;
    access(1'b0, CSR_A, 16'h0, r, v, p, s, w);
    check(v == 1'b1 && r == exp, req, {15'h0, v, r}, {16'h1, exp});
  endtask

  function automatic logic [15:0] csr_val(input logic f, input logic hv, input logic [6:0] fld,
                                          input logic wp, input logic en);
    logic [15:0] v;
    v = 16'h0;
    v[15] = f; v[14] = hv; v[2] = wp; v[0] = en;
    v = v | (16'(fld) << 5);
    return v;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] r; logic v, p, w; logic [7:0] s;
    logic [6:0] a_lo, b_lo; logic [3:0] a_hi;
    a_lo = 7'(ADDR_A >> 11); a_hi = 4'(ADDR_A >> 18); b_lo = 7'(ADDR_B >> 11);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    check(rd_valid == 1'b0 && bank_strobe == 8'h0 && wr_strobe == 1'b0, "R9 idle after reset",
          {rd_valid, bank_strobe, wr_strobe}, 0);
    csr_expect(16'h0000, "R9 register clear after reset");

    // R1 R2 table walk
    foreach (VEC[i]) begin
      logic iw; logic [21:0] ia; logic [15:0] id;
      {iw, ia, id} = VEC[i];
      access(iw, ia, id, r, v, p, s, w);
      check(s == (8'h1 << ia[7:5]), "R2 bank strobe", s, 8'h1 << ia[7:5]);
      check(w == iw, "R2 write strobe", w, iw);
      if (!iw) begin
        check(v && r == id, "R1 read data", {v, r}, {1'b1, id});
        check(p == 1'b0, "R1 no check error", p, 0);
      end else begin
        check(v == 1'b0, "R1 no rd_valid on write", v, 0);
      end
    end

    // R3 other I/O page address ignored
    access(1'b1, OTHER_IO, 16'hFFFF, r, v, p, s, w);
    check(s == 8'h0 && w == 1'b0, "R3 no strobe on foreign io write", {s, w}, 0);
    access(1'b0, OTHER_IO, 16'h0, r, v, p, s, w);
    check(v == 1'b0 && s == 8'h0, "R3 no response on foreign io read", {v, s}, 0);
    csr_expect(16'h0000, "R3 register untouched");
    access(1'b1, CSR_A, 16'h0001, r, v, p, s, w);
    check(s == 8'h0 && w == 1'b0, "R3 no strobe on register write", {s, w}, 0);
    csr_expect(16'h0001, "R3 register at strap address");

    // R4 layout and field steering
    csr_write(16'hFFFF);
    csr_expect(csr_val(1, 1, 7'h0, 1, 1), "R4 reserved zero low field loaded");
    csr_write(16'hFFFF);
    csr_expect(csr_val(1, 1, 7'h0F, 1, 1), "R4 high field loaded");
    csr_write(16'h0000);
    csr_expect(csr_val(0, 0, 7'h7F, 0, 0), "R4 low view after switch");
    csr_write(16'h0000);
    csr_expect(16'h0000, "R4 cleared");

    // R5 inverted check bits
    csr_write(16'h0005);
    access(1'b1, ADDR_A, 16'h1234, r, v, p, s, w);
    access(1'b1, ADDR_B, 16'h00FF, r, v, p, s, w);
    csr_write(16'h0001);
    access(1'b0, ADDR_A, 16'h0, r, v, p, s, w);
    check(v && r == 16'h1234, "R5 data intact", r, 16'h1234);
    check(p == 1'b1, "R5 check error raised", p, 1);

    // R6 capture and views
    csr_expect(csr_val(1, 0, a_lo, 0, 1), "R6 low view of failing address");
    csr_write(csr_val(1, 1, a_lo, 0, 1));
    csr_expect(csr_val(1, 1, 7'(a_hi), 0, 1), "R6 high view of failing address");

    // R8 first error kept
    access(1'b0, ADDR_B, 16'h0, r, v, p, s, w);
    check(p == 1'b1, "R8 second error seen", p, 1);
    csr_write(csr_val(1, 0, 7'(a_hi), 0, 1));
    csr_expect(csr_val(1, 0, a_lo, 0, 1), "R8 record unchanged");
    check(a_lo != b_lo, "R8 addresses distinct", a_lo, b_lo);

    // R7 capture disabled
    csr_write(16'h0000);
    access(1'b0, ADDR_B, 16'h0, r, v, p, s, w);
    check(p == 1'b1, "R7 error pulse with check off", p, 1);
    csr_expect(16'h0000, "R7 no capture with check off");

    // R10 same-edge capture and register write
    csr_write(16'h0001);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = ADDR_A;
    @(negedge clk);
    check(par_err == 1'b1, "R10 error in collision cycle", par_err, 1);
    req_write = 1'b1; req_addr = CSR_A; req_wdata = 16'h0001;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    csr_expect(csr_val(1, 0, a_lo, 0, 1), "R10 capture wins");

    // R9 bus init
    @(negedge clk);
    bus_init = 1'b1;
    @(negedge clk);
    bus_init = 1'b0;
    csr_expect(16'h0000, "R9 init clears");
    csr_write(16'h4000);
    csr_expect(16'h4000, "R9 high part cleared by init");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule